// File: doc/BRIEF.md
# Dual Prescaled Down-Counting Tick Timer

This block holds two identical 16-bit down-counters behind one small synchronous register port. Each counter is driven by a prescaler that divides the block clock by a power of two, at least 32. When a counter runs out it raises a one-clock interrupt pulse on its own output line. It then either reloads itself from its load register and keeps running, or stops. Software sets each channel up through three registers: control, load and count. A typical use is a periodic system tick. A 13 MHz clock, prescaler code 0 and a load of 4062 give roughly 100 expiries per second.

A channel counts only while two control bits are both set: a run bit and a clock-enable bit. Clearing either bit freezes the counter. While the channel is not counting, a read of its count register returns all-ones instead of the frozen value. The register port has no handshake. A write takes effect at the clock edge where `reg_wr` is high, and read data is a combinational function of `reg_addr`.

Top module: `dual_tick_timer`

## Requirements
- R1: After reset every control and load register reads 0, every count register reads 0xFFFF, and both interrupt lines are low.
- R2: Within a channel, control sits at offset 0x0, load at 0x2 and count at 0x4. Channel 1 answers at base 0x0000 and channel 2 at base 0x3000. In the control byte, bit 0 is run, bit 1 is auto-reload, bits 4:2 are the prescaler code, and bit 5 is clock-enable.
- R3: A counter changes only while both run and clock-enable are 1. With only one of them set, no interrupt occurs.
- R4: A count read returns the live counter value while run and clock-enable are both 1, and 0xFFFF otherwise.
- R5: With load L ≥ 1 and prescaler code p, the first interrupt comes L·32·2^p clocks after the control write that starts the channel.
- R6: Each expiry drives the channel's interrupt line high for exactly one clock.
- R7: With auto-reload set, the counter reloads from the load register on expiry and interrupts again every L·32·2^p clocks.
- R8: With auto-reload clear, expiry clears the run bit, leaves clock-enable set, and no further interrupt follows.
- R9: A load write while the channel is stopped also sets the counter. A start (run and clock-enable both becoming 1) begins counting from the load value. A load write while the channel runs does not disturb the current count; it takes effect at the next reload.
- R10: A control write replaces the whole byte, so run and clock-enable take the written values.
- R11: A load of 0 expires on the first prescaler tick, 32·2^p clocks after start.
- R12: The two channels run independently, each with its own timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the prescaler input |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 16 | Byte address of the register |
| reg_wdata | input | 16 | Write data; control writes use bits 7:0 |
| reg_rdata | output | 16 | Read data for `reg_addr`; 0 for unmapped addresses |
| tick_irq | output | 2 | One-clock expiry pulse per channel |

## Verification
A prescaler that drifts or a counter that loses or repeats a step shows as an expiry arriving at the wrong cycle. The bench therefore measures every period to the exact clock, over all eight prescaler codes and several load values. A wrong run or reload state shows at the first expiry: a one-shot that keeps firing, a reload that picks up a stale value, or a control byte read back with a bit changed. Gating errors show on the very next count read, which must switch between the live value and 0xFFFF.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  localparam logic [2:0] OFF_CTRL  = 3'h0;
  localparam logic [2:0] OFF_LOAD  = 3'h2;
  localparam logic [2:0] OFF_COUNT = 3'h4;
  localparam int         CODE_W    = 3;

  // control byte, field positions fixed by software
  typedef struct packed {
    logic [1:0]        spare;
    logic              clk_en;
    logic [CODE_W-1:0] pre;
    logic              reload;
    logic              run;
  } ctrl_t;
endpackage

// File: rtl/tmr_prescaler.sv
`timescale 1ns/1ps
module tmr_prescaler #(
  parameter int BASE_LOG2 = 5,
  parameter int CODE_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);
  localparam int PW = BASE_LOG2 + (1 << CODE_W) - 1;

  logic [PW-1:0] psc_q;
  logic [PW-1:0] limit;

  always_comb begin
    limit = {PW{1'b1}} >> (PW - BASE_LOG2 - int'(code));
    tick  = en && (psc_q >= limit);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en || tick) psc_q <= '0;
    else                       psc_q <= psc_q + 1'b1;
  end

  // R5: steady stepping of the divider between ticks
  a_r5_psc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && !$past(tick) && $stable(code)) |-> psc_q == $past(psc_q) + 1'b1);
endmodule

// File: rtl/tmr_channel.sv
`timescale 1ns/1ps
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int BASE_LOG2 = 5,
  parameter int CNT_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [2:0]       off,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rdata,
  output logic             irq
);
  ctrl_t            ctrl_q;
  ctrl_t            ctrl_new;
  logic [CNT_W-1:0] load_q, cnt_q;
  logic             active, tick, expire, ctrl_wr, load_wr, start;

  always_comb begin
    ctrl_new = ctrl_t'(wdata[7:0]);
    active   = ctrl_q.run && ctrl_q.clk_en;
    ctrl_wr  = wr && (off == OFF_CTRL);
    load_wr  = wr && (off == OFF_LOAD);
    start    = ctrl_wr && ctrl_new.run && ctrl_new.clk_en && !active;
    expire   = tick && (cnt_q <= CNT_W'(1));
  end

  tmr_prescaler #(.BASE_LOG2(BASE_LOG2), .CODE_W(CODE_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .en(active), .code(ctrl_q.pre), .tick(tick)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      load_q <= '0;
      cnt_q  <= '0;
      irq    <= 1'b0;
    end else begin
      irq <= expire;
      if (ctrl_wr)                       ctrl_q     <= ctrl_new;
      else if (expire && !ctrl_q.reload) ctrl_q.run <= 1'b0;
      if (load_wr) load_q <= wdata;
      if (start)                   cnt_q <= load_q;
      else if (load_wr && !active) cnt_q <= wdata;
      else if (expire)             cnt_q <= ctrl_q.reload ? load_q : '0;
      else if (tick)               cnt_q <= cnt_q - 1'b1;
    end
  end

  always_comb begin
    case (off)
      OFF_CTRL:  rdata = CNT_W'(ctrl_q);
      OFF_LOAD:  rdata = load_q;
      OFF_COUNT: rdata = active ? cnt_q : '1;
      default:   rdata = '0;
    endcase
  end

  a_r6_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !wr) |=> $stable(cnt_q));
  a_r8_oneshot_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !$past(wr) && !ctrl_q.reload) |-> (!ctrl_q.run && ctrl_q.clk_en));
  a_r7_reload_value: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !$past(wr) && ctrl_q.reload) |-> cnt_q == load_q);
endmodule

// File: rtl/dual_tick_timer.sv
`timescale 1ns/1ps
module dual_tick_timer #(
  parameter int ADDR_W    = 16,
  parameter int CNT_W     = 16,
  parameter int NUM_CH    = 2,
  parameter int STRIDE    = 'h3000,
  parameter int BASE_LOG2 = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  output logic [NUM_CH-1:0] tick_irq
);
  logic [NUM_CH-1:0] hit;
  logic [CNT_W-1:0]  ch_rdata [NUM_CH];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(i * STRIDE);
    assign hit[i] = (reg_addr[ADDR_W-1:3] == BASE[ADDR_W-1:3]);

    tmr_channel #(.BASE_LOG2(BASE_LOG2), .CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr && hit[i]), .off(reg_addr[2:0]),
      .wdata(reg_wdata), .rdata(ch_rdata[i]), .irq(tick_irq[i])
    );
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (hit[i]) reg_rdata = reg_rdata | ch_rdata[i];
  end

  // R2: at most one channel claims an address
  a_r2_one_hit: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit));
endmodule

// File: tb/test_dual_tick_timer.sv
`timescale 1ns/1ps
module test_dual_tick_timer;
  logic        clk = 0, rst_n = 0, reg_wr = 0;
  logic [15:0] reg_addr = 0, reg_wdata = 0;
  wire  [15:0] reg_rdata;
  wire  [1:0]  tick_irq;
  int          checks = 0, errors = 0;
  longint      cyc = 0;

  localparam logic [15:0] CH1 = 16'h0000, CH2 = 16'h3000;
  localparam logic [15:0] RUN = 16'h01, REL = 16'h02, CEN = 16'h20;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dual_tick_timer i_dual_tick_timer (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_irq(tick_irq)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(posedge clk); #1 reg_wr = 0;
  endtask

  task automatic rd_now(input logic [15:0] a, output logic [15:0] v);
    reg_addr = a; #1 v = reg_rdata;
  endtask

  task automatic rd(input logic [15:0] a, output logic [15:0] v);
    @(negedge clk); rd_now(a, v);
  endtask

  task automatic wait_irq(input int ch, input longint limit, output longint t);
    t = -1;
    for (longint k = 0; k < limit; k++) begin
      @(negedge clk);
      if (tick_irq[ch]) begin t = cyc; break; end
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] v;
    longint t0, t1, t2;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    rd(CH1 + 0, v); check("R1 ctrl", v, 0);
    rd(CH1 + 2, v); check("R1 load", v, 0);
    rd(CH1 + 4, v); check("R1 count", v, 16'hFFFF);
    rd(CH2 + 4, v); check("R1 count ch2", v, 16'hFFFF);
    check("R1 irq", tick_irq, 0);

    // R3 one enable bit alone does not count; R4 reads all-ones
    wr(CH1 + 2, 16'd1);
    wr(CH1 + 0, RUN);
    wait_irq(0, 300, t1); check("R3 run only", t1, -1);
    rd(CH1 + 4, v); check("R4 run only read", v, 16'hFFFF);
    wr(CH1 + 0, CEN);
    wait_irq(0, 300, t1); check("R3 clken only", t1, -1);
    rd(CH1 + 0, v); check("R10 ctrl replaced", v, CEN);

    // R4 live count and R9 start from load
    wr(CH1 + 2, 16'd5);
    wr(CH1 + 0, CEN | RUN); t0 = cyc;
    @(negedge clk); rd_now(CH1 + 4, v); check("R9 start value", v, 5);
    while (cyc < t0 + 70) @(negedge clk);
    rd_now(CH1 + 4, v); check("R4 live count", v, 3);
    wr(CH1 + 0, CEN);
    rd(CH1 + 4, v); check("R4 stopped read", v, 16'hFFFF);
    wr(CH1 + 2, 16'd2);
    wr(CH1 + 0, CEN | RUN); t0 = cyc;
    @(negedge clk); rd_now(CH1 + 4, v); check("R9 stopped load", v, 2);
    wait_irq(0, 1000, t1); check("R9 period from load", t1 - t0, 64);

    // R5 R8 prescaler sweep, one-shot
    for (int p = 0; p < 8; p++) begin
      wr(CH1 + 2, 16'd3);
      wr(CH1 + 0, CEN | RUN | 16'(p << 2)); t0 = cyc;
      wait_irq(0, 20000, t1);
      check($sformatf("R5 period code %0d", p), t1 - t0, 3 * (32 << p));
      @(negedge clk); check("R6 pulse width", tick_irq[0], 0);
      rd_now(CH1 + 0, v); check("R8 run cleared", v, CEN | 16'(p << 2));
    end
    wait_irq(0, 400, t1); check("R8 no refire", t1, -1);

    // R11 and load sweep with auto-reload at code 0
    for (int l = 0; l < 5; l++) begin
      wr(CH1 + 0, CEN);
      wr(CH1 + 2, 16'(l));
      wr(CH1 + 0, CEN | RUN | REL); t0 = cyc;
      wait_irq(0, 1000, t1);
      wait_irq(0, 1000, t2);
      check($sformatf("R11 first expiry load %0d", l), t1 - t0, (l == 0 ? 1 : l) * 32);
      check($sformatf("R7 reload period load %0d", l), t2 - t1, (l == 0 ? 1 : l) * 32);
    end

    // R7 repeated reload, R9 load write while running
    wr(CH1 + 0, CEN);
    wr(CH1 + 2, 16'd4);
    wr(CH1 + 0, CEN | RUN | REL); t0 = cyc;
    wait_irq(0, 1000, t1); check("R7 first", t1 - t0, 128);
    wr(CH1 + 2, 16'd2);
    wait_irq(0, 1000, t2); check("R9 running load untouched", t2 - t1, 128);
    wait_irq(0, 1000, t1); check("R7 new load period", t1 - t2, 64);
    wr(CH1 + 0, CEN);

    // R12 independent channels, R2 second base
    wr(CH1 + 2, 16'd5);
    wr(CH2 + 2, 16'd2);
    rd(CH2 + 2, v); check("R2 ch2 load", v, 2);
    wr(CH1 + 0, CEN | RUN); t0 = cyc;
    wr(CH2 + 0, CEN | RUN | 16'(1 << 2));
    wait_irq(1, 1000, t1); check("R12 ch2 period", t1 - t0, 129);
    check("R12 ch1 quiet", tick_irq[0], 0);
    wait_irq(0, 1000, t2); check("R12 ch1 period", t2 - t0, 160);
    rd(CH2 + 0, v); check("R2 ch2 ctrl", v, CEN | 16'(1 << 2));

    summary();
    $finish;
  end
endmodule